// File: doc/BRIEF.md
# Dual-Port Parity RAM

This block is a small storage macro with one write port and one read port. By default it holds 256 words of 9 bits each. The top bit of every word is a parity bit over the lower eight. The timing of each port is chosen at build time. The write port is either posted, meaning its inputs are registered and committed one edge later, or direct, meaning the array is written on the edge where the strobes are active. The read port is either combinational or clocked. A clocked read port offers two timings: one register, called transparent, or two registers, called pipelined. Everything runs on a single clock. The direct write port stands in for a strobe-timed write inside that clock domain.

Two live inputs control parity. The mode input selects one of two behaviours. In generate mode, the block recomputes the parity bit of each incoming word before storing it. In check mode, the block stores the word unchanged and raises error flags when a word violates the selected parity. Those words can be incoming write data or words being read out. The polarity input selects odd or even parity for both modes. Both ports are enabled through a pair of active-low signals, and a port acts only when both signals of its pair are low.

Top module: `ram2p_parity`

## Requirements
- R1: The array holds 2^ADDR_W words of WORD_W bits. In check mode, a word written at an address is read back unchanged, including its top (parity) bit.
- R2: A write happens only in a cycle where wrStrobeN and wrBlockN are both 0. Otherwise the array is unchanged and wrErr stays 0.
- R3: With WR_SYNC=1, a write accepted at clock edge E is committed to the array at edge E+1. A clocked read captured at edge E+1 of that address returns the old word.
- R4: With WR_SYNC=0, the array is written at the edge where the write strobes are low. A combinational read shows the new word right after that edge. A clocked read captured on that same edge returns the old word.
- R5: With RD_SYNC=1 and RD_PIPE=0, the word is captured at each edge where rdStrobeN and rdBlockN are both 0, and appears on rdData right after that edge. rdData holds its value at every other edge.
- R6: With RD_SYNC=1 and RD_PIPE=1, the captured word appears on rdData one edge later than in R5.
- R7: With RD_SYNC=0, rdData shows the addressed word combinationally while both read strobes are low. It shows 0 otherwise, and rdErr is then 0.
- R8: When genParity=1, bit 8 is replaced on write by XOR(bits 7..0) XOR parOdd. The stored 9-bit word then has an odd number of ones when parOdd=1, and an even number when parOdd=0.
- R9: wrErr is combinational. It is 1 exactly when a write is enabled, genParity=0, and the XOR of all 9 data bits differs from parOdd. It is 0 whenever genParity=1.
- R10: rdErr goes with rdData and has the same timing. It is 1 when genParity=0 and the XOR of all 9 bits of the word read differs from parOdd. It is 0 when genParity=1.
- R11: While rstN=0, the clocked read outputs are 0 and a posted write not yet committed is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rstN | input | 1 | Asynchronous active-low reset |
| genParity | input | 1 | 1 = generate parity on write, 0 = check parity |
| parOdd | input | 1 | 1 = odd parity, 0 = even parity |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | WORD_W | Write word (top bit is parity) |
| wrStrobeN | input | 1 | Active-low write strobe |
| wrBlockN | input | 1 | Active-low write block enable |
| rdAddr | input | ADDR_W | Read address |
| rdStrobeN | input | 1 | Active-low read strobe |
| rdBlockN | input | 1 | Active-low read block enable |
| rdData | output | WORD_W | Read word |
| rdErr | output | 1 | Parity violation on the word being read |
| wrErr | output | 1 | Parity violation on the incoming write word |

## Verification
A corrupted array word shows up on the first read of its address. For a combinational read, that is right away. For a transparent read, it is one edge later. For a pipelined read, it is two edges later. The word itself is wrong, and in check mode rdErr is usually wrong as well. A posted-write stage that commits too early or too late makes a read on the commit edge return the new word instead of the old one. A read stage that loads when it should hold breaks the hold at the next idle edge. Every address is written and read back on all three port-timing variants side by side, so a missing register or an extra register shows up as a one-cycle offset against the previous address's word.

// File: rtl/ram2p_pkg.sv
package ram2p_pkg;

  // Strobes decoded by the control for the datapath
  typedef struct packed {
    logic wrFire;   // write accepted this cycle
    logic rdFire;   // read enabled this cycle
    logic chkMode;  // check mode active (store as-is, report errors)
  } ramStrobes_t;

endpackage

// File: rtl/ram2p_ctrl.sv
module ram2p_ctrl
  import ram2p_pkg::*;
(
  input  logic        wrStrobeN,
  input  logic        wrBlockN,
  input  logic        rdStrobeN,
  input  logic        rdBlockN,
  input  logic        genParity,
  output ramStrobes_t strb
);

  always_comb begin
    strb.wrFire  = ~(wrStrobeN | wrBlockN);
    strb.rdFire  = ~(rdStrobeN | rdBlockN);
    strb.chkMode = ~genParity;
  end

endmodule

// File: rtl/ram2p_datapath.sv
module ram2p_datapath
  import ram2p_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 9,
  parameter bit WR_SYNC = 1'b1,
  parameter bit RD_SYNC = 1'b1,
  parameter bit RD_PIPE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ramStrobes_t       strb,
  input  logic              parOdd,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              rdErr,
  output logic              wrErr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAY_W = WORD_W - 1;

  logic [WORD_W-1:0] mem [DEPTH];

  // write side: parity generation and checking
  logic              genBit;
  logic [WORD_W-1:0] storeWord;

  always_comb begin
    genBit    = (^wrData[PAY_W-1:0]) ^ parOdd;
    storeWord = strb.chkMode ? wrData : {genBit, wrData[PAY_W-1:0]};
    wrErr     = strb.wrFire & strb.chkMode & ((^wrData) != parOdd);
  end

  logic              commitEn;
  logic [ADDR_W-1:0] commitAddr;
  logic [WORD_W-1:0] commitWord;

  generate
    if (WR_SYNC) begin : gPostedWr
      logic              pendValid;
      logic [ADDR_W-1:0] pendAddr;
      logic [WORD_W-1:0] pendWord;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pendValid <= 1'b0;
          pendAddr  <= '0;
          pendWord  <= '0;
        end else begin
          pendValid <= strb.wrFire;
          if (strb.wrFire) begin
            pendAddr <= wrAddr;
            pendWord <= storeWord;
          end
        end
      end

      assign commitEn   = pendValid;
      assign commitAddr = pendAddr;
      assign commitWord = pendWord;
    end else begin : gDirectWr
      assign commitEn   = strb.wrFire;
      assign commitAddr = wrAddr;
      assign commitWord = storeWord;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (commitEn) mem[commitAddr] <= commitWord;
  end

  // read side
  logic [WORD_W-1:0] rawWord;
  logic              rawBad;

  always_comb begin
    rawWord = mem[rdAddr];
    rawBad  = strb.chkMode & ((^rawWord) != parOdd);
  end

  generate
    if (RD_SYNC) begin : gClkRd
      logic [WORD_W-1:0] capData;
      logic              capErr;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          capData <= '0;
          capErr  <= 1'b0;
        end else if (strb.rdFire) begin
          capData <= rawWord;
          capErr  <= rawBad;
        end
      end

      if (RD_PIPE) begin : gPipe
        logic [WORD_W-1:0] outData;
        logic              outErr;

        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            outData <= '0;
            outErr  <= 1'b0;
          end else begin
            outData <= capData;
            outErr  <= capErr;
          end
        end

        assign rdData = outData;
        assign rdErr  = outErr;
      end else begin : gTransp
        assign rdData = capData;
        assign rdErr  = capErr;
      end
    end else begin : gCombRd
      assign rdData = strb.rdFire ? rawWord : '0;
      assign rdErr  = strb.rdFire & rawBad;
    end
  endgenerate

endmodule

// File: rtl/ram2p_parity.sv
module ram2p_parity
  import ram2p_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 9,
  parameter bit WR_SYNC = 1'b1,
  parameter bit RD_SYNC = 1'b1,
  parameter bit RD_PIPE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              genParity,
  input  logic              parOdd,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrStrobeN,
  input  logic              wrBlockN,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdStrobeN,
  input  logic              rdBlockN,
  output logic [WORD_W-1:0] rdData,
  output logic              rdErr,
  output logic              wrErr
);

  ramStrobes_t strb;

  ram2p_ctrl uCtrl (
    .wrStrobeN (wrStrobeN),
    .wrBlockN  (wrBlockN),
    .rdStrobeN (rdStrobeN),
    .rdBlockN  (rdBlockN),
    .genParity (genParity),
    .strb      (strb)
  );

  ram2p_datapath #(
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .WR_SYNC (WR_SYNC),
    .RD_SYNC (RD_SYNC),
    .RD_PIPE (RD_PIPE)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .parOdd (parOdd),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .rdErr  (rdErr),
    .wrErr  (wrErr)
  );

endmodule

// File: rtl/ram2p_parity_chk.sv
module ram2p_parity_chk #(
  parameter int ADDR_W  = 8,
  parameter int WORD_W  = 9,
  parameter bit RD_SYNC = 1'b1,
  parameter bit RD_PIPE = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              genParity,
  input logic              wrStrobeN,
  input logic              wrBlockN,
  input logic              rdStrobeN,
  input logic              rdBlockN,
  input logic [WORD_W-1:0] rdData,
  input logic              rdErr,
  input logic              wrErr
);

  // R2
  wr_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobeN | wrBlockN) |-> !wrErr);

  // R9
  gen_no_wrerr_chk: assert property (@(posedge clk) disable iff (!rstN)
    genParity |-> !wrErr);

  // R10
  gen_no_rderr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (genParity && $past(genParity) && $past(genParity, 2)) |-> !rdErr);

  generate
    if (RD_SYNC && !RD_PIPE) begin : gHold1
      // R5
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        $past(rdStrobeN | rdBlockN) |-> $stable(rdData));
    end else if (RD_SYNC) begin : gHold2
      // R6
      rd_pipe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        ($past(rdStrobeN | rdBlockN) && $past(rdStrobeN | rdBlockN, 2))
          |-> $stable(rdData));
    end else begin : gComb
      // R7
      rd_off_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        (rdStrobeN | rdBlockN) |-> (rdData == '0 && !rdErr));
    end
  endgenerate

endmodule

bind ram2p_parity ram2p_parity_chk #(
  .ADDR_W  (ADDR_W),
  .WORD_W  (WORD_W),
  .RD_SYNC (RD_SYNC),
  .RD_PIPE (RD_PIPE)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .genParity (genParity),
  .wrStrobeN (wrStrobeN),
  .wrBlockN  (wrBlockN),
  .rdStrobeN (rdStrobeN),
  .rdBlockN  (rdBlockN),
  .rdData    (rdData),
  .rdErr     (rdErr),
  .wrErr     (wrErr)
);

// File: tb/sim_ram2p_parity.sv
`timescale 1ns/1ps
module sim_ram2p_parity;

  logic       clk = 1'b0;
  logic       rstN;
  logic       genParity, parOdd;
  logic [7:0] wrAddr, rdAddr;
  logic [8:0] wrData;
  logic       wrStrobeN, wrBlockN, rdStrobeN, rdBlockN;
  logic [8:0] d0, d1, d2;
  logic       e0, e1, e2, w0, w1, w2;

  int checks = 0;
  int fails  = 0;

  logic [8:0] refS [256];  // posted-write instance
  logic [8:0] refA [256];  // direct-write instances

  always #4 clk = ~clk;

  ram2p_parity u0 (
    .clk(clk), .rstN(rstN), .genParity(genParity), .parOdd(parOdd),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrobeN(wrStrobeN), .wrBlockN(wrBlockN),
    .rdAddr(rdAddr), .rdStrobeN(rdStrobeN), .rdBlockN(rdBlockN),
    .rdData(d0), .rdErr(e0), .wrErr(w0));

  ram2p_parity #(.WR_SYNC(1'b0), .RD_SYNC(1'b1), .RD_PIPE(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .genParity(genParity), .parOdd(parOdd),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrobeN(wrStrobeN), .wrBlockN(wrBlockN),
    .rdAddr(rdAddr), .rdStrobeN(rdStrobeN), .rdBlockN(rdBlockN),
    .rdData(d1), .rdErr(e1), .wrErr(w1));

  ram2p_parity #(.WR_SYNC(1'b0), .RD_SYNC(1'b0), .RD_PIPE(1'b0)) u2 (
    .clk(clk), .rstN(rstN), .genParity(genParity), .parOdd(parOdd),
    .wrAddr(wrAddr), .wrData(wrData), .wrStrobeN(wrStrobeN), .wrBlockN(wrBlockN),
    .rdAddr(rdAddr), .rdStrobeN(rdStrobeN), .rdBlockN(rdBlockN),
    .rdData(d2), .rdErr(e2), .wrErr(w2));

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [8:0] wordOf(input int a);
    logic [7:0] p;
    logic       b;
    p = 8'(a * 37 + 11);
    b = ~^p;                 // correct odd parity bit
    if (a % 7 == 3) b = ~b;  // deliberately bad
    return {b, p};
  endfunction

  function automatic logic expErr(input logic [8:0] w);
    return !genParity && ((^w) != parOdd);
  endfunction

  task automatic idle();
    wrStrobeN = 1'b1; wrBlockN = 1'b1; rdStrobeN = 1'b1; rdBlockN = 1'b1;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [8:0] w);
    wrAddr = a; wrData = w; wrStrobeN = 1'b0; wrBlockN = 1'b0;
  endtask

  task automatic doRead(input logic [7:0] a);
    rdAddr = a; rdStrobeN = 1'b0; rdBlockN = 1'b0;
  endtask

  logic [8:0] oldW;

  initial begin
    rstN = 1'b0; genParity = 1'b0; parOdd = 1'b1;
    wrAddr = '0; rdAddr = '0; wrData = '0;
    idle();
    repeat (3) tick();
    // R11 reset state
    check("R11 u0 data in reset", d0, 9'h000);
    check("R11 u0 err in reset", {8'h0, e0}, 9'h000);
    check("R11 u1 data in reset", d1, 9'h000);
    check("R11 u1 err in reset", {8'h0, e1}, 9'h000);
    rstN = 1'b1;
    tick();

    // full write sweep in check mode, odd parity (R1, R9)
    for (int a = 0; a < 256; a++) begin
      doWrite(8'(a), wordOf(a));
      #1;
      check("R9 wrErr on write", {8'h0, w0}, {8'h0, (a % 7 == 3) ? 1'b1 : 1'b0});
      check("R9 wrErr direct port", {8'h0, w2}, {8'h0, (a % 7 == 3) ? 1'b1 : 1'b0});
      tick();
      refS[a] = wordOf(a);
      refA[a] = wordOf(a);
    end
    // disabled write attempts (R2)
    wrAddr = 8'd3; wrData = 9'h0AA; wrStrobeN = 1'b0; wrBlockN = 1'b1;
    #1;
    check("R2 wrErr with block off", {8'h0, w0}, 9'h000);
    tick();
    wrStrobeN = 1'b1; wrBlockN = 1'b0;
    tick();
    idle();
    tick();

    // full read sweep (R1, R5, R6, R7, R10)
    for (int a = 0; a < 256; a++) begin
      doRead(8'(a));
      #1;
      check("R7 comb read data", d2, refA[a]);
      check("R10 comb read err", {8'h0, e2}, {8'h0, expErr(refA[a])});
      tick();
      check("R5 R1 transparent data", d0, refS[a]);
      check("R10 transparent err", {8'h0, e0}, {8'h0, expErr(refS[a])});
      if (a > 0) check("R6 pipe latency", d1, refA[a-1]);
      rdStrobeN = 1'b1;
      #1;
      check("R7 comb read off", d2, 9'h000);
      tick();
      check("R6 pipe data", d1, refA[a]);
      check("R10 pipe err", {8'h0, e1}, {8'h0, expErr(refA[a])});
      check("R5 transparent hold", d0, refS[a]);
    end

    // read during posted commit (R3) and direct write (R4)
    oldW = refS[10];
    doWrite(8'd10, 9'h1C3);
    tick();
    refA[10] = 9'h1C3;
    wrStrobeN = 1'b1;
    doRead(8'd10);
    #1;
    check("R4 comb sees direct write", d2, 9'h1C3);
    tick();
    check("R3 read on commit edge old", d0, oldW);
    refS[10] = 9'h1C3;
    rdStrobeN = 1'b1;
    tick();
    check("R4 clocked read after direct write", d1, 9'h1C3);
    rdStrobeN = 1'b0;
    tick();
    check("R3 read after commit new", d0, 9'h1C3);
    idle();
    tick();

    oldW = refA[20];
    doWrite(8'd20, 9'h1F0);
    doRead(8'd20);
    #1;
    check("R4 comb before edge old", d2, oldW);
    tick();
    check("R4 comb after edge new", d2, 9'h1F0);
    refA[20] = 9'h1F0;
    idle();
    tick();
    check("R4 same-edge clocked read old", d1, oldW);
    refS[20] = 9'h1F0;
    tick();

    // generate mode (R8, R9, R10)
    genParity = 1'b1; parOdd = 1'b0;
    doWrite(8'd30, 9'h155);
    #1;
    check("R9 no wrErr in generate mode", {8'h0, w0}, 9'h000);
    tick();
    parOdd = 1'b1;
    doWrite(8'd31, 9'h006);
    tick();
    idle();
    tick();
    refS[30] = 9'h055; refA[30] = 9'h055;
    refS[31] = 9'h106; refA[31] = 9'h106;
    doRead(8'd30);
    #1;
    check("R8 even generated word", d2, 9'h055);
    tick();
    check("R8 even generated posted", d0, 9'h055);
    check("R10 no rdErr in generate mode", {8'h0, e0}, 9'h000);
    doRead(8'd31);
    #1;
    check("R8 odd generated word", d2, 9'h106);
    tick();
    check("R8 odd generated posted", d0, 9'h106);
    idle();
    genParity = 1'b0; parOdd = 1'b1;
    tick();
    doRead(8'd30);
    #1;
    check("R10 comb err on bad stored word", {8'h0, e2}, 9'h001);
    tick();
    check("R10 transparent err on bad stored word", {8'h0, e0}, 9'h001);
    idle();
    tick();

    // reset drops a pending posted write (R11)
    oldW = refS[40];
    doWrite(8'd40, 9'h1C3);
    tick();
    refA[40] = 9'h1C3;
    idle();
    rstN = 1'b0;
    #1;
    check("R11 u0 cleared by reset", d0, 9'h000);
    tick();
    rstN = 1'b1;
    tick();
    doRead(8'd40);
    #1;
    check("R11 direct write kept", d2, 9'h1C3);
    tick();
    check("R11 pending write discarded", d0, oldW);
    idle();
    tick();
    tick();
    check("R11 u1 direct write kept", d1, 9'h1C3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule